// File: doc/BRIEF.md
# Auto-Direction Half-Duplex Line Controller

This block is the digital core of a half-duplex differential bus port. The transmit data bit sets the bus direction by itself, so no separate driver enable is needed. A low data bit drives the pair to the low state for as long as it stays low. A rising data bit drives the pair high for a programmed number of clock cycles. After that window the driver lets go of the lines, and the receiver takes over so the far end can answer.

The analog parts of the port are outside this block: line drivers, thresholds and input biasing. The bus is seen through two inputs. One is an already-resolved sense bit. The other is a flag that marks the bus as idle, open or shorted; while it is set, an enabled receiver reports a failsafe high. An active-low receiver enable can keep the receiver listening at all times. A run enable puts the whole port into shutdown when it is low. On the run, data and receiver-enable inputs, an undriven or unknown level is read as 1.

All outputs are registered. Each one shows the effect of the inputs one clock after they are sampled. High impedance appears as a deasserted output enable: `drv_oe` for the pair and `rx_oe` for the receiver output.

Top module: `autodir_bus_ctrl`

## Requirements
- R1: While `run_en` is 0, `drv_oe` and `rx_oe` are 0 one clock later, whatever `tx_bit` and `rx_en_n` are.
- R2: With `run_en` 1 and `tx_bit` 0, the next clock gives `drv_oe`=1, `line_a`=0 and `line_b`=1. This holds for as long as `tx_bit` stays 0.
- R3: A 0-to-1 change of `tx_bit` gives `drv_oe`=1, `line_a`=1 and `line_b`=0 for exactly `AUTO_CYC` clocks. After that, `drv_oe` returns to 0.
- R4: With `rx_en_n` 1 and `tx_bit` 0, `rx_oe` is 0 and the bus inputs have no effect.
- R5: With `rx_en_n` 1, `rx_oe` stays 0 during the drive-high window that follows a rising `tx_bit`. After the window, `rx_oe` is 1 and `rx_out` follows `bus_bit` one clock later.
- R6: With `rx_en_n` 0 and `run_en` 1, `rx_oe` is 1 and `rx_out` follows `bus_bit` one clock later, whatever `tx_bit` is.
- R7: When `bus_fault` is 1, an enabled receiver drives `rx_out` to 1.
- R8: A rising `tx_bit` that follows a low period starts a fresh window of the full `AUTO_CYC` clocks.
- R9: A falling `tx_bit` during a window ends the window at once, and the next clock shows the drive-low state.
- R10: On the first clock after leaving shutdown, `drv_oe` stays 0 and the data level is only sampled. A `tx_bit` that is already 1 at that point is not taken as a rising edge.
- R11: While `rst_n` is low, `drv_oe` and `rx_oe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run_en | input | 1 | Active-high run enable; 0 means shutdown |
| tx_bit | input | 1 | Transmit data; its level also sets the bus direction |
| rx_en_n | input | 1 | Active-low receiver enable |
| bus_bit | input | 1 | Resolved differential bus level |
| bus_fault | input | 1 | Bus is idle, open or shorted |
| drv_oe | output | 1 | Driver output enable |
| line_a | output | 1 | Level for the true line |
| line_b | output | 1 | Level for the complement line |
| rx_oe | output | 1 | Receiver output enable |
| rx_out | output | 1 | Receiver data |

## Verification
The assertions assume that the run, data and receiver-enable inputs hold clean 0 or 1 levels once each has passed through the pull-high resolve. They also assume that every input is steady around the clock edge, because each property relates what was sampled at one edge to the registered outputs at the next. The bench changes inputs only on falling clock edges and drives only defined levels. It also holds reset long enough for the internal synchronizer to release before it applies any stimulus.

// File: rtl/autodir_pkg.sv
package autodir_pkg;
  // An undriven (Z) or unknown (X) pin is read as logic 1.
  function automatic logic pull_high(input logic v);
    return (v === 1'b0) ? 1'b0 : 1'b1;
  endfunction
endpackage

// File: rtl/autodir_rst_sync.sv
module autodir_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/autodir_window.sv
module autodir_window #(
  parameter int AUTO_CYC = 16,
  localparam int CW = $clog2(AUTO_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic dat,
  output logic armed,
  output logic hold_hi
);
  logic          armed_q, armed_d;
  logic          prev_q, prev_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          rise, upd_en;

  assign rise   = armed_q & dat & ~prev_q;
  assign upd_en = run | armed_q;

  always_comb begin
    armed_d = armed_q;
    prev_d  = prev_q;
    cnt_d   = cnt_q;
    if (!run) begin
      armed_d = 1'b0;
      prev_d  = 1'b1;
      cnt_d   = '0;
    end else begin
      armed_d = 1'b1;
      prev_d  = dat;
      if (!armed_q)           cnt_d = '0;
      else if (rise)          cnt_d = CW'(AUTO_CYC);
      else if (!dat)          cnt_d = '0;
      else if (cnt_q != '0)   cnt_d = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      prev_q  <= 1'b1;
      cnt_q   <= '0;
    end else if (upd_en) begin
      armed_q <= armed_d;
      prev_q  <= prev_d;
      cnt_q   <= cnt_d;
    end
  end

  assign armed   = armed_q;
  assign hold_hi = (cnt_d != '0);

  // R3: a running window counts down by one per clock while data stays high
  a_r3_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (run && armed_q && dat && prev_q && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CW'(1)));
  // R8: every accepted rising edge loads the full interval
  a_r8_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (run && armed_q && dat && !prev_q) |=> (cnt_q == CW'(AUTO_CYC)));
  // R10: the first sample after shutdown never opens a window
  a_r10_no_entry_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !armed_q) |=> (cnt_q == '0));
endmodule

// File: rtl/autodir_outreg.sv
module autodir_outreg (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic dat,
  input  logic rxen_n,
  input  logic bus_bit,
  input  logic bus_fault,
  input  logic armed,
  input  logic hold_hi,
  output logic drv_oe,
  output logic line_a,
  output logic line_b,
  output logic rx_oe,
  output logic rx_out
);
  logic drv_d, a_d, b_d, rxoe_d, rxo_d;

  always_comb begin
    drv_d  = run & armed & (~dat | hold_hi);
    a_d    = drv_d & dat;
    b_d    = drv_d & ~dat;
    rxoe_d = run & (~rxen_n | (dat & ~hold_hi));
    rxo_d  = rxoe_d ? (bus_fault | bus_bit) : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_oe <= 1'b0;
      line_a <= 1'b0;
      line_b <= 1'b0;
      rx_oe  <= 1'b0;
      rx_out <= 1'b1;
    end else begin
      drv_oe <= drv_d;
      line_a <= a_d;
      line_b <= b_d;
      rx_oe  <= rxoe_d;
      rx_out <= rxo_d;
    end
  end

  a_r1_shutdown: assert property (@(posedge clk) disable iff (!rst_n)
    (!run) |=> (!drv_oe && !rx_oe));
  a_r2_drive_low: assert property (@(posedge clk) disable iff (!rst_n)
    (run && armed && !dat) |=> (drv_oe && !line_a && line_b));
  a_r4_rx_off: assert property (@(posedge clk) disable iff (!rst_n)
    (rxen_n && !dat) |=> !rx_oe);
  a_r6_rx_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !rxen_n && !bus_fault) |=> (rx_oe && rx_out == $past(bus_bit)));
  a_r7_failsafe: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !rxen_n && bus_fault) |=> (rx_oe && rx_out));
  a_r3_polarity: assert property (@(posedge clk) disable iff (!rst_n)
    drv_oe |-> (line_a != line_b));
endmodule

// File: rtl/autodir_bus_ctrl.sv
module autodir_bus_ctrl #(
  parameter int AUTO_CYC  = 16,
  parameter int RST_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  input  logic tx_bit,
  input  logic rx_en_n,
  input  logic bus_bit,
  input  logic bus_fault,
  output logic drv_oe,
  output logic line_a,
  output logic line_b,
  output logic rx_oe,
  output logic rx_out
);
  import autodir_pkg::*;

  logic srst_n, run_r, dat_r, rxen_n_r, armed, hold_hi;

  assign run_r    = pull_high(run_en);
  assign dat_r    = pull_high(tx_bit);
  assign rxen_n_r = pull_high(rx_en_n);

  autodir_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n)
  );

  autodir_window #(.AUTO_CYC(AUTO_CYC)) u_win (
    .clk(clk), .rst_n(srst_n), .run(run_r), .dat(dat_r),
    .armed(armed), .hold_hi(hold_hi)
  );

  autodir_outreg u_out (
    .clk(clk), .rst_n(srst_n), .run(run_r), .dat(dat_r), .rxen_n(rxen_n_r),
    .bus_bit(bus_bit), .bus_fault(bus_fault), .armed(armed), .hold_hi(hold_hi),
    .drv_oe(drv_oe), .line_a(line_a), .line_b(line_b),
    .rx_oe(rx_oe), .rx_out(rx_out)
  );
endmodule

// File: tb/tb_autodir_bus_ctrl.sv
module tb_autodir_bus_ctrl;
  localparam int AUTO = 3;
  localparam int NV   = 22;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, run_en, tx_bit, rx_en_n, bus_bit, bus_fault;
  logic drv_oe, line_a, line_b, rx_oe, rx_out;
  int n_cmp = 0, n_bad = 0;

  autodir_bus_ctrl #(.AUTO_CYC(AUTO)) dut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .tx_bit(tx_bit),
    .rx_en_n(rx_en_n), .bus_bit(bus_bit), .bus_fault(bus_fault),
    .drv_oe(drv_oe), .line_a(line_a), .line_b(line_b),
    .rx_oe(rx_oe), .rx_out(rx_out)
  );

  // {run, tx, rxn, bus, fault} -> {drv, a, b, rxoe, rx}; lines compared only when drv expected,
  // rx_out only when rxoe expected. Window length is AUTO = 3.
  localparam logic [9:0] VEC [NV] = '{
    10'b00010_00000, // R1 shutdown
    10'b11100_00010, // R10 first sample, no drive, rx on (bus 0)
    10'b11110_00011, // R10 level high kept, no edge
    10'b10110_10100, // R2 drive low
    10'b10100_10100, // R4 bus change ignored
    10'b11110_11000, // R3 window cycle 1
    10'b11110_11000, // R5 rx held off in window
    10'b11100_11000, // R3 window cycle 3
    10'b11100_00010, // R5 released, rx follows bus 0
    10'b11110_00011, // R5 rx follows bus 1
    10'b11101_00011, // R7 failsafe with bus 0
    10'b10010_10111, // R6 rx follows while driving low
    10'b11000_11010, // R6 rx follows in window
    10'b11001_11011, // R7 failsafe while enabled low
    10'b10000_10110, // R9 fall ends window
    10'b11110_11000, // R3 new window
    10'b11110_11000, // R3
    10'b10110_10100, // R9 fall mid window
    10'b11100_11000, // R8 fresh edge after low
    10'b11100_11000, // R8
    10'b01010_00000, // R1 shutdown, data high
    10'b00011_00000  // R1 shutdown, data low
  };
  localparam int VREQ [NV] = '{1,10,10,2,4,3,5,3,5,5,7,6,6,7,9,3,3,9,8,8,1,1};

  task automatic check(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic drive(input logic r, input logic d, input logic rn, input logic b, input logic f);
    run_en = r; tx_bit = d; rx_en_n = rn; bus_bit = b; bus_fault = f;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int hi_cnt;
    string tag;
    drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R11 drv_oe", drv_oe, 1'b0);
    check("R11 rx_oe", rx_oe, 1'b0);
    // R11: outputs stay off in reset even with run requested
    drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    check("R11 drv_oe run", drv_oe, 1'b0);
    check("R11 rx_oe run", rx_oe, 1'b0);
    drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][9], VEC[i][8], VEC[i][7], VEC[i][6], VEC[i][5]);
      @(negedge clk);
      tag = $sformatf("R%0d row%0d", VREQ[i], i);
      check({tag, " drv_oe"}, drv_oe, VEC[i][4]);
      if (VEC[i][4]) begin
        check({tag, " line_a"}, line_a, VEC[i][3]);
        check({tag, " line_b"}, line_b, VEC[i][2]);
      end
      check({tag, " rx_oe"}, rx_oe, VEC[i][1]);
      if (VEC[i][1]) check({tag, " rx_out"}, rx_out, VEC[i][0]);
    end

    // R10: leave shutdown with data already high: no drive on the first two clocks
    drive(1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    check("R10 entry clk1", drv_oe, 1'b0);
    @(negedge clk);
    check("R10 entry clk2", drv_oe, 1'b0);

    // R8: fall then rise gives exactly AUTO clocks of drive high
    tx_bit = 1'b0;
    @(negedge clk);
    check("R8 low before edge", line_b, 1'b1);
    tx_bit = 1'b1;
    hi_cnt = 0;
    for (int k = 0; k < AUTO + 3; k++) begin
      @(negedge clk);
      if (drv_oe && line_a && !line_b) hi_cnt++;
    end
    check("R8 window length ok", (hi_cnt == AUTO), 1'b1);
    if (hi_cnt != AUTO) $display("FAIL R8: got %0d expected %0d clocks", hi_cnt, AUTO);
    check("R3 released after window", drv_oe, 1'b0);

    // R9: falling edge one clock into a window switches straight to drive low
    tx_bit = 1'b0;
    @(negedge clk);
    tx_bit = 1'b1;
    @(negedge clk);
    check("R9 window open", line_a, 1'b1);
    tx_bit = 1'b0;
    @(negedge clk);
    check("R9 drv_oe", drv_oe, 1'b1);
    check("R9 line_a", line_a, 1'b0);
    check("R9 line_b", line_b, 1'b1);

    // R1: shutdown in the middle of a window
    tx_bit = 1'b1;
    @(negedge clk);
    run_en = 1'b0;
    @(negedge clk);
    check("R1 mid-window drv_oe", drv_oe, 1'b0);
    check("R1 mid-window rx_oe", rx_oe, 1'b0);

    finish_run();
  end
endmodule